// File: doc/BRIEF.md
# Double-Width Compare-and-Exchange Sequencer

This block carries out an atomic compare-and-exchange on a memory operand twice the width of one register. A caller gives it a base address, a half-size (4 or 8 bytes), a lock request, two expected halves and two replacement halves, and pulses a start input. The sequencer then reads the low half at the base address and the high half one half-size above it. It compares them with the expected values, low half first, and writes both halves back. On a match the replacement values go to memory. On a mismatch memory receives its own contents again and the expected-value outputs take the values that were read.

Every access uses one request/acknowledge port with separate read and write strobes. A lock qualifier turns the two reads into locked read-for-store accesses and the two writes into store-and-unlock accesses. The qualifier stays high for the whole read-modify-write window. A one-cycle done pulse marks the end of the operation. At that point the updated expected halves and the zero flag are valid, and they hold until the next operation is accepted.

Top module: `wide_cas_seq`

## Requirements
- R1: Reads are made at two addresses. The first read is at the base address and returns the low half. The second read is at the base address plus the half-size, which is 8 bytes when `wide_i`=1 and 4 bytes when `wide_i`=0, and returns the high half.
- R2: `zf_o` is 1 after an operation only when both halves in memory equal the expected halves over the active width. A low-half difference alone forces `zf_o`=0.
- R3: On a match, the replacement high half is written at base plus half-size and the replacement low half is written at base. `exp_lo_o` and `exp_hi_o` keep the expected inputs.
- R4: On a mismatch, `exp_lo_o` and `exp_hi_o` take the values read from memory, and memory is written back with its original contents.
- R5: Each operation makes exactly four accesses in this order: read low, read high, write high, write low. Every request asserts exactly one of `mem_rd_o` and `mem_wr_o`.
- R6: When `lock_i`=1 at start, `mem_lock_o` is high without a gap from the first read request until the low-half write is acknowledged, and low afterwards. When `lock_i`=0, `mem_lock_o` stays low.
- R7: An access keeps its request, strobe, address, write data and lock value unchanged until `mem_ack_i` is sampled high, and the sequencer advances only on that acknowledge.
- R8: `done_o` is high for exactly one cycle, in the cycle after the low-half write is acknowledged. `exp_lo_o`, `exp_hi_o` and `zf_o` are valid in that cycle and stay unchanged after it.
- R9: A `start_i` pulse while an operation is in progress has no effect. The running operation completes with the inputs captured at its own start.
- R10: With `wide_i`=0, only bits 31:0 of each half are read, compared and written. Bits above 31 of the write data, of `exp_lo_o` and of `exp_hi_o` are zero.
- R11: After reset, no request is made and `done_o`, `zf_o`, `mem_lock_o`, `exp_lo_o` and `exp_hi_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation; honoured only when idle |
| addr_i | input | ADDR_W | Base byte address of the low half |
| wide_i | input | 1 | 1: 8-byte halves, 0: 4-byte halves |
| lock_i | input | 1 | Use locked read-for-store and store-unlock accesses |
| exp_lo_i | input | DATA_W | Expected low half |
| exp_hi_i | input | DATA_W | Expected high half |
| new_lo_i | input | DATA_W | Replacement low half |
| new_hi_i | input | DATA_W | Replacement high half |
| mem_req_o | output | 1 | Memory access request |
| mem_ack_i | input | 1 | Memory access acknowledge |
| mem_lock_o | output | 1 | Lock qualifier for the access window |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_addr_o | output | ADDR_W | Access byte address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data |
| exp_lo_o | output | DATA_W | Updated expected low half |
| exp_hi_o | output | DATA_W | Updated expected high half |
| zf_o | output | 1 | Zero flag: both halves matched |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the defaults DATA_W=64 and ADDR_W=32, so both the 8-byte and the 4-byte half-size can be reached at run time through `wide_i`. The wide setting exercises full 64-bit compares and 8-byte address steps. The narrow setting lets the memory model return garbage above bit 31, which shows whether those bits are masked out of the compare and the results. A memory model with random acknowledge latency places the hold-until-acknowledge behaviour and the lock window under stall. Start pulses with different inputs injected mid-operation test that a busy sequencer ignores them.

// File: rtl/wcas_pkg.sv
package wcas_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_LO,
    ST_RD_HI,
    ST_CMP,
    ST_WR_HI,
    ST_WR_LO,
    ST_DONE
  } wcas_state_e;
endpackage

// File: rtl/wcas_cmp.sv
module wcas_cmp #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [1:0][DATA_W-1:0] exp_i,
  input  logic [1:0][DATA_W-1:0] mem_i,
  output logic                   lo_eq_o,
  output logic                   match_o
);
  logic [1:0] eq;

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign eq[h] = (exp_i[h] == mem_i[h]);
  end

  // high compare only counts once the low halves agree
  assign lo_eq_o = eq[0];
  assign match_o = eq[0] ? eq[1] : 1'b0;
endmodule

// File: rtl/wcas_ctrl.sv
module wcas_ctrl
  import wcas_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        lock_i,
  input  logic        ack_i,
  output wcas_state_e state_o,
  output logic        launch_o,
  output logic        req_o,
  output logic        rd_o,
  output logic        wr_o,
  output logic        lock_o,
  output logic        done_o
);
  wcas_state_e state_q, state_d;
  logic        lock_q;

  assign launch_o = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_RD_LO;
      ST_RD_LO: if (ack_i)   state_d = ST_RD_HI;
      ST_RD_HI: if (ack_i)   state_d = ST_CMP;
      ST_CMP:                state_d = ST_WR_HI;
      ST_WR_HI: if (ack_i)   state_d = ST_WR_LO;
      ST_WR_LO: if (ack_i)   state_d = ST_DONE;
      ST_DONE:               state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lock_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (launch_o) lock_q <= lock_i;
    end
  end

  assign rd_o    = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
  assign wr_o    = (state_q == ST_WR_HI) || (state_q == ST_WR_LO);
  assign req_o   = rd_o || wr_o;
  // window spans both reads, the compare and both writes
  assign lock_o  = lock_q && (rd_o || wr_o || (state_q == ST_CMP));
  assign done_o  = (state_q == ST_DONE);
  assign state_o = state_q;
endmodule

// File: rtl/wcas_dp.sv
module wcas_dp
  import wcas_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  wcas_state_e       state_i,
  input  logic              ack_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] exp_lo_i,
  input  logic [DATA_W-1:0] exp_hi_i,
  input  logic [DATA_W-1:0] new_lo_i,
  input  logic [DATA_W-1:0] new_hi_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] exp_lo_o,
  output logic [DATA_W-1:0] exp_hi_o,
  output logic              zf_o
);
  localparam int unsigned NARROW_W     = DATA_W / 2;
  localparam int unsigned WIDE_BYTES   = DATA_W / 8;
  localparam int unsigned NARROW_BYTES = DATA_W / 16;

  function automatic logic [DATA_W-1:0] half_mask(input logic wide);
    return wide ? {DATA_W{1'b1}} : {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  endfunction

  logic [ADDR_W-1:0] base_q, hi_addr;
  logic              wide_q, zf_q;
  logic [DATA_W-1:0] elo_q, ehi_q, nlo_q, nhi_q, mlo_q, mhi_q, wlo_q, whi_q;
  logic [DATA_W-1:0] in_mask, mask_q;
  logic              lo_eq, match;

  assign in_mask = half_mask(wide_i);
  assign mask_q  = half_mask(wide_q);
  assign hi_addr = base_q + (wide_q ? ADDR_W'(WIDE_BYTES) : ADDR_W'(NARROW_BYTES));

  wcas_cmp #(.DATA_W(DATA_W)) i_cmp (
    .exp_i   ({ehi_q, elo_q}),
    .mem_i   ({mhi_q, mlo_q}),
    .lo_eq_o (lo_eq),
    .match_o (match)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      wide_q <= 1'b0;
      zf_q   <= 1'b0;
      elo_q  <= '0;
      ehi_q  <= '0;
      nlo_q  <= '0;
      nhi_q  <= '0;
      mlo_q  <= '0;
      mhi_q  <= '0;
      wlo_q  <= '0;
      whi_q  <= '0;
    end else begin
      if (launch_i) begin
        base_q <= addr_i;
        wide_q <= wide_i;
        zf_q   <= 1'b0;
        elo_q  <= exp_lo_i & in_mask;
        ehi_q  <= exp_hi_i & in_mask;
        nlo_q  <= new_lo_i & in_mask;
        nhi_q  <= new_hi_i & in_mask;
      end
      if (state_i == ST_RD_LO && ack_i) mlo_q <= rdata_i & mask_q;
      if (state_i == ST_RD_HI && ack_i) mhi_q <= rdata_i & mask_q;
      if (state_i == ST_CMP) begin
        zf_q <= match;
        if (match) begin
          wlo_q <= nlo_q;
          whi_q <= nhi_q;
        end else begin
          // memory contents go back unchanged and into the expected pair
          elo_q <= mlo_q;
          ehi_q <= mhi_q;
          wlo_q <= mlo_q;
          whi_q <= mhi_q;
        end
      end
    end
  end

  logic unused_lo_eq;
  assign unused_lo_eq = lo_eq;

  assign addr_o   = (state_i == ST_RD_HI || state_i == ST_WR_HI) ? hi_addr : base_q;
  assign wdata_o  = (state_i == ST_WR_HI) ? whi_q : wlo_q;
  assign exp_lo_o = elo_q;
  assign exp_hi_o = ehi_q;
  assign zf_o     = zf_q;
endmodule

// File: rtl/wide_cas_seq.sv
module wide_cas_seq
  import wcas_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wide_i,
  input  logic              lock_i,
  input  logic [DATA_W-1:0] exp_lo_i,
  input  logic [DATA_W-1:0] exp_hi_i,
  input  logic [DATA_W-1:0] new_lo_i,
  input  logic [DATA_W-1:0] new_hi_i,
  output logic              mem_req_o,
  input  logic              mem_ack_i,
  output logic              mem_lock_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] exp_lo_o,
  output logic [DATA_W-1:0] exp_hi_o,
  output logic              zf_o,
  output logic              done_o
);
  wcas_state_e state;
  logic        launch;

  wcas_ctrl i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .lock_i   (lock_i),
    .ack_i    (mem_ack_i),
    .state_o  (state),
    .launch_o (launch),
    .req_o    (mem_req_o),
    .rd_o     (mem_rd_o),
    .wr_o     (mem_wr_o),
    .lock_o   (mem_lock_o),
    .done_o   (done_o)
  );

  wcas_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .state_i  (state),
    .ack_i    (mem_ack_i),
    .addr_i   (addr_i),
    .wide_i   (wide_i),
    .exp_lo_i (exp_lo_i),
    .exp_hi_i (exp_hi_i),
    .new_lo_i (new_lo_i),
    .new_hi_i (new_hi_i),
    .rdata_i  (mem_rdata_i),
    .addr_o   (mem_addr_o),
    .wdata_o  (mem_wdata_o),
    .exp_lo_o (exp_lo_o),
    .exp_hi_o (exp_hi_o),
    .zf_o     (zf_o)
  );
endmodule

// File: rtl/wcas_checker.sv
module wcas_checker #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic              mem_ack_i,
  input logic              mem_lock_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic [DATA_W-1:0] exp_lo_o,
  input logic [DATA_W-1:0] exp_hi_o,
  input logic              zf_o,
  input logic              done_o
);
  p_one_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_rd_o ^ mem_wr_o));

  p_no_idle_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_o |-> !(mem_rd_o || mem_wr_o));

  p_hold_until_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_rd_o) && $stable(mem_addr_o)
                                   && $stable(mem_wdata_o) && $stable(mem_lock_o)));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_wr_o && mem_ack_i));

  p_results_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ($stable(exp_lo_o) && $stable(exp_hi_o) && $stable(zf_o)));

  p_lock_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_lock_o) |-> $past(mem_wr_o && mem_ack_i));
endmodule

bind wide_cas_seq wcas_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_wcas_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_ack_i   (mem_ack_i),
  .mem_lock_o  (mem_lock_o),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .exp_lo_o    (exp_lo_o),
  .exp_hi_o    (exp_hi_o),
  .zf_o        (zf_o),
  .done_o      (done_o)
);

// File: tb/test_wide_cas_seq.sv
`timescale 1ns/1ps
module test_wide_cas_seq;
  localparam int DW = 64;
  localparam int AW = 32;

  logic          clk, rst_n, start, wide, lock, ack;
  logic [AW-1:0] addr;
  logic [DW-1:0] elo, ehi, nlo, nhi, rdata;
  logic          mem_req_o, mem_lock_o, mem_rd_o, mem_wr_o, zf_o, done_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o, exp_lo_o, exp_hi_o;

  wide_cas_seq #(.DATA_W(DW), .ADDR_W(AW)) i_wide_cas_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .wide_i(wide),
    .lock_i(lock), .exp_lo_i(elo), .exp_hi_i(ehi), .new_lo_i(nlo), .new_hi_i(nhi),
    .mem_req_o(mem_req_o), .mem_ack_i(ack), .mem_lock_o(mem_lock_o),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(rdata), .exp_lo_o(exp_lo_o),
    .exp_hi_o(exp_hi_o), .zf_o(zf_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model
  logic [7:0] mem [0:255];
  int         cur_bytes;
  bit         log_wr [0:7];
  logic [7:0] log_addr [0:7];
  bit         log_lk [0:7];
  logic [63:0] log_data [0:7];
  int         log_n;

  initial begin
    int lat;
    ack = 1'b0;
    rdata = '0;
    lat = 0;
    forever begin
      @(negedge clk);
      ack = 1'b0;
      if (rst_n && mem_req_o) begin
        if (lat == 0) begin
          if (log_n < 8) begin
            log_wr[log_n]   = mem_wr_o;
            log_addr[log_n] = mem_addr_o[7:0];
            log_lk[log_n]   = mem_lock_o;
            log_data[log_n] = mem_wdata_o;
          end
          log_n++;
          if (mem_rd_o) begin
            for (int i = 0; i < 8; i++)
              rdata[8*i +: 8] = (i < cur_bytes) ? mem[(int'(mem_addr_o[7:0]) + i) & 255]
                                                : 8'($urandom);
          end else begin
            for (int i = 0; i < cur_bytes; i++)
              mem[(int'(mem_addr_o[7:0]) + i) & 255] = mem_wdata_o[8*i +: 8];
          end
          ack = 1'b1;
          lat = $urandom_range(0, 2);
        end else begin
          lat--;
        end
      end
    end
  end

  function automatic void model(input bit w, input logic [63:0] mlo, mhi, xlo, xhi, rlo, rhi,
                                output bit eq, output logic [63:0] olo, ohi, wlo, whi);
    logic [63:0] msk;
    msk = w ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    eq  = ((xlo & msk) == (mlo & msk)) && ((xhi & msk) == (mhi & msk));
    olo = eq ? (xlo & msk) : (mlo & msk);
    ohi = eq ? (xhi & msk) : (mhi & msk);
    wlo = eq ? (rlo & msk) : (mlo & msk);
    whi = eq ? (rhi & msk) : (mhi & msk);
  endfunction

  int lock_gap;
  bit cur_lock;

  task automatic step_mon();
    @(negedge clk);
    if (!done_o && mem_lock_o !== cur_lock) lock_gap++;
  endtask

  task automatic run_op(input bit w, input bit lk, input logic [7:0] base,
                        input logic [63:0] mlo, mhi, xlo, xhi, rlo, rhi, input bit poke);
    bit eq;
    logic [63:0] olo, ohi, wlo, whi, got_lo, got_hi;
    int bytes, cnt;
    bytes = w ? 8 : 4;
    cur_bytes = bytes;
    for (int i = 0; i < 8; i++) begin
      mem[(int'(base) + i) & 255]         = 8'($urandom);
      mem[(int'(base) + 8 + i) & 255]     = 8'($urandom);
    end
    for (int i = 0; i < bytes; i++) begin
      mem[(int'(base) + i) & 255]         = mlo[8*i +: 8];
      mem[(int'(base) + bytes + i) & 255] = mhi[8*i +: 8];
    end
    model(w, mlo, mhi, xlo, xhi, rlo, rhi, eq, olo, ohi, wlo, whi);
    log_n = 0;
    lock_gap = 0;
    cur_lock = lk;
    wide = w; lock = lk; addr = {24'h0, base};
    elo = xlo; ehi = xhi; nlo = rlo; nhi = rhi;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mem_lock_o !== cur_lock) lock_gap++;
    if (poke) begin
      // R9: disturb inputs and restart while busy
      wide = ~w; lock = ~lk; addr = 32'h80;
      elo = {$urandom, $urandom}; ehi = ~xhi; nlo = ~rlo; nhi = ~rhi;
      start = 1'b1;
      step_mon();
      start = 1'b0;
    end
    cnt = 0;
    while (!done_o && cnt < 200) begin
      step_mon();
      cnt++;
    end
    chk(done_o === 1'b1, "R8 done seen", 64'(done_o), 64'd1);
    chk(log_n == 4, "R5 access count", 64'(log_n), 64'd4);
    chk(!log_wr[0] && !log_wr[1] && log_wr[2] && log_wr[3], "R5 access order",
        {60'd0, log_wr[3], log_wr[2], log_wr[1], log_wr[0]}, 64'hC);
    chk(log_addr[0] == base, "R1 low read address", 64'(log_addr[0]), 64'(base));
    chk(log_addr[1] == 8'(int'(base) + bytes), "R1 high read address",
        64'(log_addr[1]), 64'(8'(int'(base) + bytes)));
    chk(log_addr[2] == 8'(int'(base) + bytes), "R5 high write address",
        64'(log_addr[2]), 64'(8'(int'(base) + bytes)));
    chk(log_addr[3] == base, "R5 low write address", 64'(log_addr[3]), 64'(base));
    chk(log_lk[0] == lk && log_lk[1] == lk && log_lk[2] == lk && log_lk[3] == lk,
        "R6 lock per access", {60'd0, log_lk[3], log_lk[2], log_lk[1], log_lk[0]},
        lk ? 64'hF : 64'h0);
    chk(lock_gap == 0, "R6 lock window", 64'(lock_gap), 64'd0);
    chk(zf_o === eq, "R2 zero flag", 64'(zf_o), 64'(eq));
    if (eq) begin
      chk(log_data[2] === whi, "R3 high write data", log_data[2], whi);
      chk(log_data[3] === wlo, "R3 low write data", log_data[3], wlo);
      chk(exp_lo_o === olo, "R3 exp_lo kept", exp_lo_o, olo);
      chk(exp_hi_o === ohi, "R3 exp_hi kept", exp_hi_o, ohi);
    end else begin
      chk(log_data[2] === whi, "R4 high write-back", log_data[2], whi);
      chk(log_data[3] === wlo, "R4 low write-back", log_data[3], wlo);
      chk(exp_lo_o === olo, "R4 exp_lo loaded", exp_lo_o, olo);
      chk(exp_hi_o === ohi, "R4 exp_hi loaded", exp_hi_o, ohi);
    end
    if (!w) chk(exp_lo_o[63:32] == 32'd0 && exp_hi_o[63:32] == 32'd0 &&
                log_data[2][63:32] == 32'd0, "R10 upper bits zero",
                {exp_lo_o[63:32], exp_hi_o[63:32]}, 64'd0);
    got_lo = '0; got_hi = '0;
    for (int i = 0; i < bytes; i++) begin
      got_lo[8*i +: 8] = mem[(int'(base) + i) & 255];
      got_hi[8*i +: 8] = mem[(int'(base) + bytes + i) & 255];
    end
    chk(got_lo === wlo && got_hi === whi, poke ? "R9 memory after ignored start" : "R3 memory image",
        got_lo ^ wlo, got_hi ^ whi);
    @(negedge clk);
    chk(done_o === 1'b0, "R8 done single cycle", 64'(done_o), 64'd0);
    chk(exp_lo_o === olo && zf_o === eq, "R8 results hold", exp_lo_o, olo);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] a, b;
    void'($urandom(32'h5EED_0C45));
    rst_n = 1'b0; start = 1'b0; wide = 1'b1; lock = 1'b0; addr = '0;
    elo = '0; ehi = '0; nlo = '0; nhi = '0; log_n = 0; cur_bytes = 8;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req_o && !done_o && !zf_o && !mem_lock_o, "R11 reset control",
        {60'd0, mem_req_o, done_o, zf_o, mem_lock_o}, 64'd0);
    chk(exp_lo_o == '0 && exp_hi_o == '0, "R11 reset results", exp_lo_o | exp_hi_o, 64'd0);

    a = 64'h0123_4567_89AB_CDEF; b = 64'hFEDC_BA98_7654_3210;
    // wide match, unlocked
    run_op(1, 0, 8'h10, a, b, a, b, 64'h1111, 64'h2222, 0);
    // wide low mismatch, locked
    run_op(1, 1, 8'h20, a, b, ~a, b, 64'h3333, 64'h4444, 0);
    // wide high-only mismatch, locked
    run_op(1, 1, 8'h30, a, b, a, b ^ 64'h1, 64'h5, 64'h6, 0);
    // narrow match despite differing upper bits (R10)
    run_op(0, 0, 8'h40, a, b, {32'hDEAD_BEEF, a[31:0]}, {32'hCAFE_F00D, b[31:0]},
           64'hAAAA_AAAA_5555_5555, 64'h9999_9999_7777_7777, 0);
    // narrow mismatch, locked
    run_op(0, 1, 8'h50, a, b, a, ~b, 64'h7, 64'h8, 0);
    // start while busy, match and mismatch (R9)
    run_op(1, 1, 8'h60, a, b, a, b, 64'hABCD, 64'hEF01, 1);
    run_op(0, 0, 8'h70, a, b, b, a, 64'h1, 64'h2, 1);
    // top of the modelled window
    run_op(1, 0, 8'hF0, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF,
           64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 0);

    for (int k = 0; k < 60; k++) begin
      logic [63:0] ml, mh, xl, xh;
      int mode;
      ml = {$urandom, $urandom}; mh = {$urandom, $urandom};
      mode = $urandom_range(0, 3);
      xl = (mode == 1 || mode == 3) ? {$urandom, $urandom} : ml;
      xh = (mode == 2 || mode == 3) ? {$urandom, $urandom} : mh;
      run_op(1'($urandom), 1'($urandom), 8'($urandom_range(0, 13) * 16), ml, mh, xl, xh,
             {$urandom, $urandom}, {$urandom, $urandom}, ($urandom_range(0, 2) == 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule